// File: doc/BRIEF.md
# Device-Side Command Mailbox Controller

This block is the device end of a command mailbox that a host drives through a simple word-wide register bus. The host places an opcode, an input length and payload words into the block. It then sets a doorbell bit. While the doorbell is set, the device side owns the mailbox: the opcode and length go to a back-end executor through a valid/ready request, and the executor reads and writes the payload RAM through a private port. The executor's response supplies a return code, an output length and a flag marking the command as still running in the background. The block stores the return code and the output length, then drops the doorbell to hand ownership back to the host.

A command that finishes in the background opens a separate tracking path. The executor reports percent complete, and the block saturates that value at 100. When the value reaches 100, the block latches a deferred return code and, if the host enabled it, emits a one-cycle completion interrupt pulse. While background work runs, only the health-query opcode is forwarded. Any other doorbell completes at once with a busy return code. A device-status ready bit tells the host when the mailbox may first be used.

Register word index (reg_addr with bit ADDR_W-1 clear): 0 capabilities, 1 control, 2 opcode, 3 length, 4 status, 5 background status, 6 background return code, 7 device status. With bit ADDR_W-1 set, reg_addr[PW_W-1:0] selects a payload word.

Top module: `cmdbox_dev`

## Requirements
- R1: After reset the doorbell (control bit 0), the interrupt enable (control bit 1), the status return code and the background status word all read 0. The capabilities word holds PAY_LOG2 in bits [4:0], background-interrupt support in bit 6 and MSG_NUM in bits [11:8].
- R2: Device-status bit 0 reads 0 until READY_DLY cycles after reset and then stays 1. A doorbell write made before it is set is ignored.
- R3: Writing 1 to control bit 0 while the mailbox is idle sets the doorbell and raises req_valid with the stored opcode and length. Both are held stable until req_ready is seen.
- R4: While the doorbell is set, host writes to the opcode, length and payload words are ignored. A further doorbell write has no effect, and writing 0 to control bit 0 does not clear it.
- R5: A response (rsp_valid) stores rsp_rc in the status word and rsp_len in the length word, capped at 2^PAY_LOG2 bytes. The doorbell clears on the same edge.
- R6: The back-end payload port writes only while a response is awaited; at other times its writes are ignored. The host payload window accepts writes only while the doorbell is clear.
- R7: Once the doorbell has cleared, the status word and the payload RAM do not change until the next doorbell, apart from host writes.
- R8: A response with rsp_bg set starts background tracking. Background status then reads active in bit 31, the command's opcode in bits [15:0] and 0 in the percent field [22:16].
- R9: Percent updates (bg_upd) saturate at 100. At 100 the background work ends (bit 31 clears) and bg_rc is latched into the background return-code word.
- R10: During background work, a doorbell for HEALTH_OP is forwarded as a normal request. Any other opcode raises no request; its doorbell clears within two cycles with RC_BUSY in the status word.
- R11: bg_irq is a single-cycle pulse on the edge after background completion. It is emitted only if control bit 1 was set and support is built in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata after the edge |
| reg_addr | input | ADDR_W | Register or payload word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | Command request to the executor |
| req_ready | input | 1 | Executor accepts the request |
| req_op | output | 16 | Request opcode |
| req_len | output | 21 | Request input length in bytes |
| rsp_valid | input | 1 | Executor response strobe |
| rsp_rc | input | 16 | Response return code |
| rsp_len | input | 21 | Response output length in bytes |
| rsp_bg | input | 1 | Command continues in background |
| pay_idx | input | PW_W | Executor payload word index |
| pay_we | input | 1 | Executor payload write enable |
| pay_wdata | input | 32 | Executor payload write data |
| pay_rdata | output | 32 | Executor payload read data (combinational) |
| bg_upd | input | 1 | Background progress update strobe |
| bg_pct | input | 7 | Background percent complete |
| bg_rc | input | 16 | Background final return code |
| bg_irq | output | 1 | Background completion interrupt pulse |

## Verification
The bench builds the block with a 256-byte payload area (PAY_LOG2 = 8, 64 words), so an executor reply of 300 bytes exercises the length cap. READY_DLY = 16 is short enough to read the ready bit both before and after it rises. The interrupt-support variant is on, so that the pulse can be observed both with the enable set and with it cleared. A percent value of 120 checks the saturation, and a busy background phase checks both the forwarding of the health opcode and the refusal of other opcodes.

// File: rtl/cmdbox_pkg.sv
package cmdbox_pkg;
    localparam int OP_W   = 16;
    localparam int LEN_W  = 21;
    localparam int RC_W   = 16;
    localparam int DATA_W = 32;
    localparam int PCT_W  = 7;

    localparam logic [2:0] A_CAPS  = 3'd0;
    localparam logic [2:0] A_CTRL  = 3'd1;
    localparam logic [2:0] A_OP    = 3'd2;
    localparam logic [2:0] A_LEN   = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;
    localparam logic [2:0] A_BGST  = 3'd5;
    localparam logic [2:0] A_BGRC  = 3'd6;
    localparam logic [2:0] A_DEV   = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_REJ  = 2'd3
    } mb_state_t;

    typedef struct packed {
        mb_state_t          st;
        logic [OP_W-1:0]    op;
        logic [LEN_W-1:0]   len;
        logic [RC_W-1:0]    rc;
        logic               irq_en;
        logic [DATA_W-1:0]  rdata;
    } mb_regs_t;

    typedef struct packed {
        logic               active;
        logic [OP_W-1:0]    op;
        logic [PCT_W-1:0]   pct;
        logic [RC_W-1:0]    rc;
        logic               irq;
    } bg_regs_t;
endpackage

// File: rtl/cmdbox_ready_timer.sv
module cmdbox_ready_timer #(
    parameter int READY_DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CW = $clog2(READY_DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(READY_DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == LIMIT);

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

// File: rtl/cmdbox_payload_ram.sv
module cmdbox_payload_ram #(
    parameter int WORDS  = 64,
    parameter int DATA_W = 32,
    localparam int IW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [IW-1:0]     h_idx,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              b_we,
    input  logic [IW-1:0]     b_idx,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (h_we)      mem_q[h_idx] <= h_wdata;
        else if (b_we) mem_q[b_idx] <= b_wdata;
    end

    assign h_rdata = mem_q[h_idx];
    assign b_rdata = mem_q[b_idx];

    // R6: ownership is exclusive, host and executor never write together
    assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_we && b_we));
endmodule

// File: rtl/cmdbox_bg_tracker.sv
module cmdbox_bg_tracker
    import cmdbox_pkg::*;
#(
    parameter bit IRQ_SUP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OP_W-1:0]  start_op,
    input  logic             upd,
    input  logic [PCT_W-1:0] upd_pct,
    input  logic [RC_W-1:0]  upd_rc,
    input  logic             irq_en,
    output logic             active,
    output logic [OP_W-1:0]  op,
    output logic [PCT_W-1:0] pct,
    output logic [RC_W-1:0]  rc,
    output logic             irq
);
    localparam logic [PCT_W-1:0] FULL = PCT_W'(100);

    bg_regs_t s_d, s_q;
    logic [PCT_W-1:0] sat;
    logic             gate_irq;

    generate
        if (IRQ_SUP) begin : g_irq
            assign gate_irq = irq_en;
        end else begin : g_noirq
            assign gate_irq = 1'b0;
        end
    endgenerate

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        sat     = (upd_pct > FULL) ? FULL : upd_pct;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.op     = start_op;
                s_d.pct    = '0;
                s_d.rc     = '0;
            end
        end else if (upd) begin
            s_d.pct = sat;
            if (sat == FULL) begin
                s_d.active = 1'b0;
                s_d.rc     = upd_rc;
                s_d.irq    = gate_irq;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;
    assign op     = s_q.op;
    assign pct    = s_q.pct;
    assign rc     = s_q.rc;
    assign irq    = s_q.irq;

    assert_pct_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pct <= FULL);
    assert_irq_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pct == FULL) && !active);
    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && upd && !irq_en) |=> !irq);
endmodule

// File: rtl/cmdbox_dev.sv
module cmdbox_dev
    import cmdbox_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          PAY_LOG2  = 8,
    parameter int          READY_DLY = 16,
    parameter bit          IRQ_SUP   = 1'b1,
    parameter logic [3:0]  MSG_NUM   = 4'd3,
    parameter logic [15:0] HEALTH_OP = 16'h4200,
    parameter logic [15:0] RC_BUSY   = 16'h0010,
    localparam int PW_W = PAY_LOG2 - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [15:0]       req_op,
    output logic [20:0]       req_len,
    input  logic              rsp_valid,
    input  logic [15:0]       rsp_rc,
    input  logic [20:0]       rsp_len,
    input  logic              rsp_bg,
    input  logic [PW_W-1:0]   pay_idx,
    input  logic              pay_we,
    input  logic [31:0]       pay_wdata,
    output logic [31:0]       pay_rdata,
    input  logic              bg_upd,
    input  logic [6:0]        bg_pct,
    input  logic [15:0]       bg_rc,
    output logic              bg_irq
);
    localparam int WORDS = 1 << PW_W;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1 << PAY_LOG2);

    mb_regs_t r_d, r_q;

    logic              ready;
    logic              win;
    logic [2:0]        ridx;
    logic              idle;
    logic              h_we, b_we;
    logic [DATA_W-1:0] h_rdata;
    logic              bg_start, bg_active;
    logic [OP_W-1:0]   bg_op;
    logic [PCT_W-1:0]  bg_pct_q;
    logic [RC_W-1:0]   bg_rc_q;
    logic              ring;

    cmdbox_ready_timer #(.READY_DLY(READY_DLY)) u_ready (
        .clk(clk), .rst_n(rst_n), .ready(ready));

    assign win  = reg_addr[ADDR_W-1];
    assign ridx = reg_addr[2:0];
    assign idle = (r_q.st == ST_IDLE);
    assign h_we = reg_wr && win && idle;
    assign b_we = pay_we && (r_q.st == ST_WAIT);
    assign ring = reg_wr && !win && (ridx == A_CTRL) && reg_wdata[0];

    cmdbox_payload_ram #(.WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_we), .h_idx(reg_addr[PW_W-1:0]), .h_wdata(reg_wdata), .h_rdata(h_rdata),
        .b_we(b_we), .b_idx(pay_idx), .b_wdata(pay_wdata), .b_rdata(pay_rdata));

    assign bg_start = (r_q.st == ST_WAIT) && rsp_valid && rsp_bg;

    cmdbox_bg_tracker #(.IRQ_SUP(IRQ_SUP)) u_bg (
        .clk(clk), .rst_n(rst_n),
        .start(bg_start), .start_op(r_q.op),
        .upd(bg_upd), .upd_pct(bg_pct), .upd_rc(bg_rc),
        .irq_en(r_q.irq_en),
        .active(bg_active), .op(bg_op), .pct(bg_pct_q), .rc(bg_rc_q),
        .irq(bg_irq));

    always_comb begin
        r_d = r_q;
        // control write: enable bit any time, doorbell only when idle
        if (reg_wr && !win && ridx == A_CTRL)
            r_d.irq_en = reg_wdata[1] & IRQ_SUP;
        unique case (r_q.st)
            ST_IDLE: begin
                if (reg_wr && !win && ridx == A_OP)  r_d.op  = reg_wdata[OP_W-1:0];
                if (reg_wr && !win && ridx == A_LEN) r_d.len = reg_wdata[LEN_W-1:0];
                if (ring && ready) begin
                    if (bg_active && r_q.op != HEALTH_OP) r_d.st = ST_REJ;
                    else                                  r_d.st = ST_REQ;
                end
            end
            ST_REQ:  if (req_ready) r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rsp_valid) begin
                    r_d.rc  = rsp_rc;
                    r_d.len = (rsp_len > MAX_LEN) ? MAX_LEN : rsp_len;
                    r_d.st  = ST_IDLE;
                end
            end
            ST_REJ: begin
                r_d.rc = RC_BUSY;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (reg_rd) begin
            if (win) r_d.rdata = h_rdata;
            else begin
                unique case (ridx)
                    A_CAPS: r_d.rdata = {20'd0, MSG_NUM, 1'b0, IRQ_SUP, 1'b0, 5'(PAY_LOG2)};
                    A_CTRL: r_d.rdata = {30'd0, r_q.irq_en, !idle};
                    A_OP:   r_d.rdata = {16'd0, r_q.op};
                    A_LEN:  r_d.rdata = {11'd0, r_q.len};
                    A_STAT: r_d.rdata = {16'd0, r_q.rc};
                    A_BGST: r_d.rdata = {bg_active, 8'd0, bg_pct_q, bg_op};
                    A_BGRC: r_d.rdata = {16'd0, bg_rc_q};
                    default: r_d.rdata = {31'd0, ready};
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign reg_rdata = r_q.rdata;
    assign req_valid = (r_q.st == ST_REQ);
    assign req_op    = r_q.op;
    assign req_len   = r_q.len;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid && $stable(req_op) && $stable(req_len));
    assert_busy_cmd_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REQ) |=> $stable(r_q.op));
    assert_rc_frozen_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !(ring && ready)) |=> $stable(r_q.rc));
    assert_len_capped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_WAIT) && rsp_valid) |=> (r_q.len <= MAX_LEN) && idle);
    assert_reject_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REJ) |=> !req_valid && r_q.rc == RC_BUSY);
endmodule

// File: tb/cmdbox_dev_test.sv
`timescale 1ns/1ps
module cmdbox_dev_test;
    localparam int PW_W = 6;
    localparam logic [15:0] HOP = 16'h4200;
    localparam logic [15:0] RCB = 16'h0010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic req_valid, req_ready = 0;
    logic [15:0] req_op;
    logic [20:0] req_len;
    logic rsp_valid = 0, rsp_bg = 0;
    logic [15:0] rsp_rc = 0;
    logic [20:0] rsp_len = 0;
    logic [PW_W-1:0] pay_idx = 0;
    logic pay_we = 0;
    logic [31:0] pay_wdata = 0, pay_rdata;
    logic bg_upd = 0;
    logic [6:0] bg_pct = 0;
    logic [15:0] bg_rc = 0;
    logic bg_irq;

    int checks = 0, fails = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    cmdbox_dev #(.ADDR_W(8), .PAY_LOG2(8), .READY_DLY(16), .IRQ_SUP(1'b1),
                 .MSG_NUM(4'd3), .HEALTH_OP(HOP), .RC_BUSY(RCB)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_rc(rsp_rc), .rsp_len(rsp_len), .rsp_bg(rsp_bg),
        .pay_idx(pay_idx), .pay_we(pay_we), .pay_wdata(pay_wdata), .pay_rdata(pay_rdata),
        .bg_upd(bg_upd), .bg_pct(bg_pct), .bg_rc(bg_rc), .bg_irq(bg_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic accept();
        @(negedge clk); req_ready = 1;
        @(negedge clk); req_ready = 0;
    endtask

    task automatic respond(input logic [15:0] rc, input logic [20:0] len, input logic bg);
        @(negedge clk); rsp_valid = 1; rsp_rc = rc; rsp_len = len; rsp_bg = bg;
        @(negedge clk); rsp_valid = 0; rsp_bg = 0;
    endtask

    task automatic progress(input logic [6:0] p, input logic [15:0] rc);
        @(negedge clk); bg_upd = 1; bg_pct = p; bg_rc = rc;
        @(negedge clk); bg_upd = 0;
    endtask

    task automatic t_reset();
        rdreg(8'h07, rd); chk("R2 not ready early", rd, 32'h0);
        wr(8'h01, 32'h1);
        @(negedge clk); chk("R2 early doorbell ignored", {31'd0, req_valid}, 32'h0);
        rdreg(8'h01, rd); chk("R1 ctrl reset", rd, 32'h0);
        rdreg(8'h04, rd); chk("R1 status reset", rd, 32'h0);
        rdreg(8'h05, rd); chk("R1 bg status reset", rd, 32'h0);
        rdreg(8'h00, rd); chk("R1 caps", rd, 32'h0000_0348);
        repeat (20) @(negedge clk);
        rdreg(8'h07, rd); chk("R2 ready", rd, 32'h1);
    endtask

    task automatic t_basic();
        wr(8'h80, 32'h0000_00A5);
        wr(8'h03, 32'd4);
        wr(8'h02, 32'h1234);
        wr(8'h01, 32'h1);
        chk("R3 req_valid", {31'd0, req_valid}, 32'h1);
        chk("R3 req_op", {16'd0, req_op}, 32'h1234);
        chk("R3 req_len", {11'd0, req_len}, 32'd4);
        wr(8'h02, 32'h9999);
        wr(8'h80, 32'h1111_1111);
        wr(8'h01, 32'h0);
        chk("R3 held until ready", {31'd0, req_valid}, 32'h1);
        chk("R4 op ignored while busy", {16'd0, req_op}, 32'h1234);
        rdreg(8'h01, rd); chk("R4 doorbell not cleared by host", rd, 32'h1);
        accept();
        pay_idx = 0;
        @(negedge clk); chk("R4 payload write ignored while busy", pay_rdata, 32'h0000_00A5);
        pay_idx = 1; pay_wdata = 32'hBEEF; pay_we = 1;
        @(negedge clk); pay_we = 0;
        respond(16'h0000, 21'd8, 1'b0);
        rdreg(8'h01, rd); chk("R5 doorbell cleared", rd, 32'h0);
        rdreg(8'h04, rd); chk("R5 status rc", rd, 32'h0);
        rdreg(8'h03, rd); chk("R5 out length", rd, 32'd8);
        rdreg(8'h81, rd); chk("R6 executor payload write", rd, 32'h0000_BEEF);
        pay_idx = 1; pay_wdata = 32'hDEAD; pay_we = 1;
        @(negedge clk); pay_we = 0;
        rdreg(8'h81, rd); chk("R7 executor write ignored when idle", rd, 32'h0000_BEEF);
        rdreg(8'h02, rd); chk("R4 opcode kept", rd, 32'h1234);
    endtask

    task automatic t_cap();
        wr(8'h02, 32'h0055);
        wr(8'h01, 32'h1);
        accept();
        respond(16'h0007, 21'd300, 1'b0);
        rdreg(8'h03, rd); chk("R5 length capped", rd, 32'd256);
        rdreg(8'h04, rd); chk("R5 error rc", rd, 32'h7);
        repeat (3) @(negedge clk);
        rdreg(8'h04, rd); chk("R7 rc stable idle", rd, 32'h7);
    endtask

    task automatic t_bg();
        int pulses;
        wr(8'h01, 32'h2);
        wr(8'h02, 32'h4400);
        wr(8'h01, 32'h3);
        accept();
        respond(16'h0001, 21'd0, 1'b1);
        rdreg(8'h05, rd); chk("R8 bg started", rd, 32'h8000_4400);
        progress(7'd50, 16'h0);
        rdreg(8'h05, rd); chk("R9 pct 50", rd, 32'h8032_4400);
        chk("R11 no irq mid-way", {31'd0, bg_irq}, 32'h0);
        wr(8'h02, 32'h0066);
        wr(8'h01, 32'h3);
        chk("R10 non-health not forwarded", {31'd0, req_valid}, 32'h0);
        rdreg(8'h01, rd); chk("R10 doorbell cleared", rd, 32'h2);
        rdreg(8'h04, rd); chk("R10 busy rc", rd, {16'd0, RCB});
        wr(8'h02, {16'd0, HOP});
        wr(8'h01, 32'h3);
        chk("R10 health forwarded", {31'd0, req_valid}, 32'h1);
        accept();
        respond(16'h0000, 21'd16, 1'b0);
        pulses = 0;
        @(negedge clk); bg_upd = 1; bg_pct = 7'd120; bg_rc = 16'h0009;
        @(negedge clk); bg_upd = 0; if (bg_irq) pulses++;
        @(negedge clk); if (bg_irq) pulses++;
        chk("R11 single pulse", pulses, 1);
        rdreg(8'h05, rd); chk("R9 saturated and done", rd, 32'h0064_4400);
        rdreg(8'h06, rd); chk("R9 final rc", rd, 32'h9);
    endtask

    task automatic t_noirq();
        int pulses;
        wr(8'h01, 32'h0);
        wr(8'h02, 32'h4401);
        wr(8'h01, 32'h1);
        accept();
        respond(16'h0001, 21'd0, 1'b1);
        pulses = 0;
        progress(7'd100, 16'h0004);
        if (bg_irq) pulses++;
        @(negedge clk); if (bg_irq) pulses++;
        chk("R11 no irq when disabled", pulses, 0);
        rdreg(8'h06, rd); chk("R9 rc at exactly 100", rd, 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_cap();
        t_bg();
        t_noirq();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule